// File: doc/BRIEF.md
# Branch Trace Buffer

This block keeps a short history of taken program-flow changes. Each record holds two addresses: where the branch came from and where it went. A core-side strobe, valid for one cycle, offers a source and a target address. Software controls the block and drains it through three word registers on a simple read/write register bus.

Software powers the block and arms recording through a control register. It learns how many complete records are held from a status register. It then drains the history through a data register, newest record first. Each record takes two reads: the target comes first and the source second. The count drops only once the second word has gone out. When the store is full, the oldest record gives way to the new one and a sticky overflow flag is raised.

Top module: `branch_trace_buf`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0 and `reg_rdata` is 0.
- R2: Register offsets are 0x0 for control, 0x4 for status and 0x8 for data. A read presents its word on `reg_rdata` one cycle after `reg_rd` is high. In the control word, bit 0 is power, bit 1 is record enable and bit 2 is the overflow flag. Every other bit reads 0, including the compression field in bits 4:3, which is not implemented.
- R3: A cycle with `br_take` high stores one record of `br_src` and `br_dst` only if power and enable are both 1. In any other case the strobe is ignored.
- R4: A status read returns, in its low bits, the number of complete records held before that cycle's updates.
- R5: Data reads drain the records in last-in first-out order.
- R6: For each record, the first data read returns the target address and the second returns the source address.
- R7: The count stays the same after the first word of a record is read. It drops by one after the second word.
- R8: Writing 1 to the control word stops recording and keeps the stored records readable.
- R9: A control write with bit 0 clear empties the store, restarts the word phase and clears the overflow flag.
- R10: The store holds DEPTH records (16 by default). A capture while full discards the oldest record, leaves the count at DEPTH and sets the overflow flag.
- R11: A control write with bit 2 clear clears the overflow flag. A control write with bit 2 set leaves the flag unchanged.
- R12: A data read while the count is 0 returns 0 and changes neither the count nor the word phase.
- R13: If a capture and a data read fall in the same cycle, the capture is applied first. The read returns the new record's target, and the next data read returns that record's source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_take | input | 1 | Taken branch strobe |
| br_src | input | AW | Address of the branch |
| br_dst | input | AW | Branch target address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data, one cycle after `reg_rd` |

## Verification
A taken-branch capture and a data-register read can fall in the same cycle. This is the case where the pop order and the word phase are most easily broken. The bench provokes it with a directed case in which a branch arrives between the two halves of a pair. Random traffic also raises strobes and reads together. Each read value is judged against a bench-side stack model, which applies the capture before the read and restarts the word phase. A follow-up read then confirms that the source word of the new record comes next.

// File: rtl/branch_trace_buf.sv
module branch_trace_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int RAW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           br_take,
  input  logic [AW-1:0]  br_src,
  input  logic [AW-1:0]  br_dst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [RAW-1:0] A_CTRL = RAW'(0);
  localparam logic [RAW-1:0] A_STAT = RAW'(4);
  localparam logic [RAW-1:0] A_DATA = RAW'(8);

  logic [AW-1:0] src_mem [DEPTH];
  logic [AW-1:0] dst_mem [DEPTH];
  logic [PW-1:0] wp;
  logic [CW-1:0] cnt;
  logic          ph, pwr, en, ovf;

  wire cap    = br_take & pwr & en;
  wire wr_ctl = reg_wr && (reg_addr == A_CTRL);
  wire kill   = wr_ctl && !reg_wdata[0];
  wire rd_dat = reg_rd && (reg_addr == A_DATA);
  wire full   = (cnt == CW'(DEPTH));
  wire empty  = (cnt == '0);
  wire [PW-1:0] top = wp - PW'(1);
  wire unused_wdata = ^reg_wdata[AW-1:3];

  always_ff @(posedge clk) begin
    if (cap) begin
      src_mem[wp] <= br_src;
      dst_mem[wp] <= br_dst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr <= 1'b0;
      en  <= 1'b0;
    end else if (wr_ctl) begin
      pwr <= reg_wdata[0];
      en  <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
      ph  <= 1'b0;
      ovf <= 1'b0;
    end else if (kill) begin
      wp  <= '0;
      cnt <= '0;
      ph  <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (cap) begin
        wp <= wp + PW'(1);
        if (!full) cnt <= cnt + CW'(1);
        ph <= rd_dat;
      end else if (rd_dat && !empty) begin
        ph <= ~ph;
        if (ph) begin
          wp  <= top;
          cnt <= cnt - CW'(1);
        end
      end
      ovf <= (wr_ctl ? (ovf & reg_wdata[2]) : ovf) | (cap & full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= AW'({ovf, en, pwr});
        A_STAT:  reg_rdata <= AW'(cnt);
        A_DATA:  reg_rdata <= cap ? br_dst : empty ? '0 : ph ? src_mem[top] : dst_mem[top];
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/branch_trace_buf_chk.sv
module branch_trace_buf_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap,
  input logic          rd_dat,
  input logic          kill,
  input logic          full,
  input logic          empty,
  input logic          ph,
  input logic          ovf,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] reg_rdata
);
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_capture_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap && !full && !kill |=> cnt == $past(cnt) + CW'(1));

  p_first_word_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dat && !cap && !empty && !ph && !kill |=> cnt == $past(cnt) && ph);

  p_second_word_pops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dat && !cap && !empty && ph && !kill |=> cnt == $past(cnt) - CW'(1) && !ph);

  p_power_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> cnt == '0 && !ph && !ovf);

  p_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap && full && !kill |=> ovf && full);

  p_empty_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dat && empty && !cap |=> reg_rdata == '0 && cnt == '0);

  p_same_cycle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dat && cap && !kill |=> ph);
endmodule

bind branch_trace_buf branch_trace_buf_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap(cap), .rd_dat(rd_dat), .kill(kill),
  .full(full), .empty(empty), .ph(ph), .ovf(ovf), .cnt(cnt), .reg_rdata(reg_rdata)
);

// File: tb/branch_trace_buf_bench.sv
module branch_trace_buf_bench;
  localparam int D = 16;
  logic clk = 0, rst_n = 0;
  logic br_take = 0, reg_wr = 0, reg_rd = 0;
  logic [31:0] br_src = 0, br_dst = 0, reg_wdata = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] ms [D];
  logic [31:0] md [D];
  int mc = 0;
  bit mph = 0, mpw = 0, men = 0, movf = 0;

  always #10 clk = ~clk;

  branch_trace_buf u_branch_trace_buf (
    .clk(clk), .rst_n(rst_n), .br_take(br_take), .br_src(br_src), .br_dst(br_dst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] expect_read(input bit cap, input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'h0: return {29'd0, movf, men, mpw};
      4'h4: return 32'(mc);
      4'h8: return cap ? d : (mc == 0) ? 32'd0 : mph ? ms[mc-1] : md[mc-1];
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input bit take, input logic [31:0] s, input logic [31:0] d,
                      input bit rd, input bit wr, input logic [3:0] a,
                      input logic [31:0] wd, input string req);
    bit cap, kill, wrc, rdd, was_full;
    logic [31:0] exp;
    br_take = take; br_src = s; br_dst = d;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    cap = take && mpw && men;
    wrc = wr && a == 4'h0;
    kill = wrc && !wd[0];
    rdd = rd && a == 4'h8;
    was_full = (mc == D);
    exp = expect_read(cap, a, d);
    if (kill) begin
      mc = 0; mph = 0; movf = 0;
    end else begin
      if (cap) begin
        if (was_full) begin
          for (int i = 0; i < D - 1; i++) begin ms[i] = ms[i+1]; md[i] = md[i+1]; end
          ms[D-1] = s; md[D-1] = d;
        end else begin
          ms[mc] = s; md[mc] = d; mc++;
        end
        mph = rdd;
      end else if (rdd && mc > 0) begin
        if (mph) mc--;
        mph = !mph;
      end
      movf = (wrc ? (movf & wd[2]) : movf) | (cap & was_full);
    end
    if (wrc) begin mpw = wd[0]; men = wd[1]; end
    @(negedge clk);
    br_take = 0; reg_rd = 0; reg_wr = 0;
    if (rd) check(reg_rdata, exp, req);
  endtask

  task automatic wr_ctl(input logic [31:0] v, input string req);
    step(0, 0, 0, 0, 1, 4'h0, v, req);
  endtask
  task automatic rd_reg(input logic [3:0] a, input string req);
    step(0, 0, 0, 1, 0, a, 0, req);
  endtask
  task automatic branch(input logic [31:0] s, input logic [31:0] d, input string req);
    step(1, s, d, 0, 0, 4'h0, 0, req);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(reg_rdata, 0, "R1 rdata after reset");
    rd_reg(4'h0, "R1 control after reset");
    rd_reg(4'h4, "R1 status after reset");
    rd_reg(4'h8, "R12 empty data read");
    rd_reg(4'h4, "R12 count unchanged");

    branch(32'h100, 32'h200, "R3 ignored when off");
    rd_reg(4'h4, "R3 no record when off");
    wr_ctl(32'hFFFF_FFFF, "R2 write all ones");
    rd_reg(4'h0, "R2 unused bits zero");
    rd_reg(4'hC, "R2 unmapped offset");

    branch(32'h224, 32'h250, "R3");
    branch(32'h25a, 32'h234, "R3");
    branch(32'h23c, 32'h26c, "R3");
    wr_ctl(32'h1, "R8 stop");
    branch(32'h999, 32'h888, "R8 ignored");
    rd_reg(4'h4, "R4 count of three");
    for (int k = 0; k < 3; k++) begin
      rd_reg(4'h8, "R5 R6 target first");
      rd_reg(4'h4, "R7 count held mid pair");
      rd_reg(4'h8, "R6 source second");
      rd_reg(4'h4, "R7 count after pair");
    end
    rd_reg(4'h8, "R12 empty read zero");
    rd_reg(4'h4, "R12 count still zero");

    wr_ctl(32'h3, "R10 arm");
    for (int k = 0; k < D + 2; k++) branch(32'h1000 + 32'(k), 32'h8000 + 32'(k), "R10");
    rd_reg(4'h4, "R10 count saturates");
    rd_reg(4'h0, "R10 overflow flag");
    wr_ctl(32'h7, "R11 keep flag");
    rd_reg(4'h0, "R11 flag kept");
    wr_ctl(32'h3, "R11 clear flag");
    rd_reg(4'h0, "R11 flag cleared");
    for (int k = 0; k < 2 * D; k++) rd_reg(4'h8, "R5 R10 drain order");

    branch(32'hA0, 32'hB0, "R13 setup");
    rd_reg(4'h8, "R13 setup target");
    step(1, 32'hC0, 32'hD0, 1, 0, 4'h8, 0, "R13 same cycle returns new target");
    rd_reg(4'h8, "R13 then new source");
    rd_reg(4'h4, "R13 count");
    rd_reg(4'h8, "R13 older target");

    branch(32'h11, 32'h22, "R9 setup");
    wr_ctl(32'h0, "R9 power off");
    rd_reg(4'h4, "R9 count cleared");
    wr_ctl(32'h3, "R9 rearm");
    rd_reg(4'h8, "R9 empty after power off");

    for (int k = 0; k < 1500; k++) begin
      int op;
      op = int'($urandom_range(0, 99));
      if (op < 35)
        branch($urandom, $urandom, "R3 random");
      else if (op < 60)
        rd_reg(4'h8, "R5 R6 random data");
      else if (op < 72)
        step(1, $urandom, $urandom, 1, 0, 4'h8, 0, "R13 random");
      else if (op < 84)
        rd_reg(4'h4, "R4 R7 random status");
      else if (op < 92)
        rd_reg(4'h0, "R2 R11 random control");
      else if (op < 97)
        wr_ctl(($urandom_range(0, 1) != 0) ? 32'h3 : 32'h7, "R11 random write");
      else
        wr_ctl(($urandom_range(0, 3) == 0) ? 32'h0 : 32'h1, "R8 R9 random write");
    end
    done = 1;
    report();
  end
endmodule